// File: doc/BRIEF.md
# Parallel-to-Serial Word Shifter

The block turns a parallel word into a stream of narrow chunks for a serial link such as an SPI master. A word is offered with `ld_valid`. It is taken on a clock edge where `stall` is low. From then on, each cycle with `shift_en` high moves one chunk of `STEP_W` bits onto `ser_out`. The chunk count per word is `WORD_W / STEP_W`. The default word is 8 bits wide.

The bit order is chosen per word: `lsb_first` is captured when the word is taken and holds for the whole transfer. `stall` stays high from the load until the last chunk has been shifted out. While it is high, further loads are refused, so a source that holds `ld_valid` only has its next word taken after the current transfer ends. A one-cycle `done` pulse marks the end of each transfer.

Top module: `ser_shifter`

## Requirements
- R1: With `stall` low, a clock edge where `ld_valid` is high takes `ld_data`. `stall` is high after that edge, and the first chunk is on `ser_out` in the same cycle.
- R2: With `lsb_first` = 0 at load, chunk k (k = 0 first) is `ld_data[WORD_W-1-k*STEP_W -: STEP_W]`, with bit order kept inside the chunk.
- R3: With `lsb_first` = 1 at load, chunk k is `ld_data[k*STEP_W +: STEP_W]`, with bit order kept inside the chunk.
- R4: While `stall` is high, an edge with `shift_en` high advances `ser_out` by exactly one chunk. An edge with `shift_en` low leaves `ser_out` unchanged.
- R5: `stall` stays high through exactly `WORD_W/STEP_W` shift edges and is low after the final one. Every chunk of every accepted word is delivered.
- R6: `done` is high for exactly the one cycle after the final shift edge of a word and is low at all other times.
- R7: While `stall` is high, `ld_valid` and `ld_data` have no effect on the chunk sequence.
- R8: With `stall` low, a load and a shift in the same cycle perform the load only. The shift is dropped and all chunks of the new word follow.
- R9: A load offered in the cycle of the final shift is refused. It is taken in the following cycle if `ld_valid` is still high, with one idle cycle between transfers.
- R10: Changing `lsb_first` during a transfer does not alter the order of the word already taken.
- R11: During and after reset, `stall` and `done` are 0. Whenever `stall` is low, `ser_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_valid | input | 1 | A parallel word is offered |
| ld_data | input | WORD_W | Parallel word |
| lsb_first | input | 1 | 1: least significant chunk first; 0: most significant first |
| shift_en | input | 1 | Advance one chunk this cycle |
| stall | output | 1 | Transfer in progress; loads are refused |
| ser_out | output | STEP_W | Current outgoing chunk |
| done | output | 1 | One-cycle pulse after the final chunk |

## Verification
Two collisions matter for this block. The first is a load and a shift in the same cycle while the block is idle. The second is a held load that arrives in the cycle of the final shift. The bench drives `ld_valid` and `shift_en` high together in both cases: once from idle, and once for the whole length of a transfer with a second word waiting. A scoreboard queue, filled only on cycles where `stall` is low, predicts the chunk order. It also predicts the one idle cycle with a `done` pulse between the two words, and every deviation at `ser_out`, `stall` or `done` is reported.

// File: rtl/ser_pkg.sv
`timescale 1ns/1ps
package ser_pkg;
   typedef enum logic {
      ORDER_MSB = 1'b0,
      ORDER_LSB = 1'b1
   } order_e;

   function automatic int chunk_count(input int word_w, input int step_w);
      return word_w / step_w;
   endfunction
endpackage

// File: rtl/ser_ctrl.sv
`timescale 1ns/1ps
module ser_ctrl #(
   parameter int STEPS = 8,
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_valid,
   input  logic             shift_en,
   output logic             busy,
   output logic [CNT_W-1:0] remain,
   output logic             load_go,
   output logic             shift_go,
   output logic             done
);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(STEPS);
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

   logic last_step;

   // loads only when idle, so a load never competes with a live shift
   assign load_go   = ld_valid & ~busy;
   assign shift_go  = shift_en & busy;
   assign last_step = shift_go & (remain == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         remain <= '0;
         done   <= 1'b0;
      end else begin
         done <= last_step;
         if (load_go) begin
            busy   <= 1'b1;
            remain <= FULL;
         end else if (shift_go) begin
            remain <= remain - ONE;
            if (last_step) busy <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/ser_datapath.sv
`timescale 1ns/1ps
module ser_datapath
   import ser_pkg::*;
#(
   parameter int WORD_W = 8,
   parameter int STEP_W = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_go,
   input  logic              shift_go,
   input  logic [WORD_W-1:0] ld_data,
   input  logic              lsb_first,
   output logic [STEP_W-1:0] ser_out
);
   localparam int STEPS = WORD_W / STEP_W;

   logic [WORD_W-1:0] sreg;
   logic [WORD_W-1:0] sreg_next;
   order_e            order_q;

   generate
      if (STEPS == 1) begin : g_single
         // whole word leaves in one step
         assign sreg_next = '0;
      end else begin : g_multi
         always_comb begin
            if (order_q == ORDER_LSB) sreg_next = sreg >> STEP_W;
            else                      sreg_next = sreg << STEP_W;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg    <= '0;
         order_q <= ORDER_MSB;
      end else if (load_go) begin
         sreg    <= ld_data;
         order_q <= order_e'(lsb_first);
      end else if (shift_go) begin
         sreg <= sreg_next;
      end
   end

   assign ser_out = (order_q == ORDER_LSB) ? sreg[STEP_W-1:0]
                                           : sreg[WORD_W-1 -: STEP_W];
endmodule

// File: rtl/ser_shifter.sv
`timescale 1ns/1ps
module ser_shifter
   import ser_pkg::*;
#(
   parameter int WORD_W = 8,
   parameter int STEP_W = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_valid,
   input  logic [WORD_W-1:0] ld_data,
   input  logic              lsb_first,
   input  logic              shift_en,
   output logic              stall,
   output logic [STEP_W-1:0] ser_out,
   output logic              done
);
   localparam int STEPS = chunk_count(WORD_W, STEP_W);
   localparam int CNT_W = $clog2(STEPS + 1);

   initial begin
      assert (STEP_W >= 1 && STEP_W <= WORD_W)
         else $error("ser_shifter: STEP_W out of range");
      assert (WORD_W % STEP_W == 0)
         else $error("ser_shifter: STEP_W must divide WORD_W");
   end

   logic             busy;
   logic [CNT_W-1:0] remain;
   logic             load_go;
   logic             shift_go;

   ser_ctrl #(.STEPS(STEPS), .CNT_W(CNT_W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_valid (ld_valid),
      .shift_en (shift_en),
      .busy     (busy),
      .remain   (remain),
      .load_go  (load_go),
      .shift_go (shift_go),
      .done     (done)
   );

   ser_datapath #(.WORD_W(WORD_W), .STEP_W(STEP_W)) u_dp (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_go   (load_go),
      .shift_go  (shift_go),
      .ld_data   (ld_data),
      .lsb_first (lsb_first),
      .ser_out   (ser_out)
   );

   assign stall = busy;
endmodule

// File: rtl/ser_shifter_chk.sv
`timescale 1ns/1ps
module ser_shifter_chk #(
   parameter int WORD_W = 8,
   parameter int STEP_W = 1,
   parameter int CNT_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ld_valid,
   input logic              shift_en,
   input logic              stall,
   input logic [STEP_W-1:0] ser_out,
   input logic              done,
   input logic [CNT_W-1:0]  remain
);
   localparam int STEPS = WORD_W / STEP_W;

   a_r1_load_sets_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (!stall && ld_valid) |=> stall);

   a_r1_full_count: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stall) |-> (remain == CNT_W'(STEPS)));

   a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (stall && shift_en && remain > CNT_W'(1)) |=>
         (stall && remain == $past(remain) - CNT_W'(1)));

   a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (stall && !shift_en) |=> (stall && $stable(ser_out)));

   a_r5_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
      (stall && shift_en && remain == CNT_W'(1)) |=> (!stall && done));

   a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !stall);

   a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !stall |-> (ser_out == '0));
endmodule

bind ser_shifter ser_shifter_chk #(
   .WORD_W (WORD_W),
   .STEP_W (STEP_W),
   .CNT_W  (CNT_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ld_valid (ld_valid),
   .shift_en (shift_en),
   .stall    (stall),
   .ser_out  (ser_out),
   .done     (done),
   .remain   (remain)
);

// File: tb/ser_shifter_bench.sv
`timescale 1ns/1ps
module ser_shifter_bench;
   localparam int W     = 8;
   localparam int S     = 2;
   localparam int STEPS = W / S;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         ld_valid = 1'b0;
   logic [W-1:0] ld_data = '0;
   logic         lsb_first = 1'b0;
   logic         shift_en = 1'b0;
   logic         stall;
   logic [S-1:0] ser_out;
   logic         done;

   int checks = 0;
   int errors = 0;

   typedef struct {
      logic [S-1:0] chunk;
      bit           last;
   } item_t;
   item_t q[$];

   bit pending_done = 0;
   bit pending_load = 0;

   always #10 clk = ~clk;

   ser_shifter #(.WORD_W(W), .STEP_W(S)) u_ser_shifter (
      .clk       (clk),
      .rst_n     (rst_n),
      .ld_valid  (ld_valid),
      .ld_data   (ld_data),
      .lsb_first (lsb_first),
      .shift_en  (shift_en),
      .stall     (stall),
      .ser_out   (ser_out),
      .done      (done)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // expected chunk sequence of an accepted word (R2 / R3)
   task automatic push_word(input logic [W-1:0] d, input logic lsb);
      for (int k = 0; k < STEPS; k++) begin
         item_t it;
         if (lsb) it.chunk = S'(d >> (k * S));
         else     it.chunk = S'(d >> (W - S - k * S));
         it.last = (k == STEPS - 1);
         q.push_back(it);
      end
   endtask

   // monitor: samples at the falling edge, inputs change just after rising edges
   always @(negedge clk) begin
      if (rst_n) begin
         if (pending_done) begin
            chk(done == 1'b1, "R6 done after final shift", done, 1);
            chk(stall == 1'b0, "R5/R9 stall low after final shift", stall, 0);
            pending_done = 0;
         end else if (done) begin
            chk(1'b0, "R6 unexpected done", done, 0);
         end
         if (pending_load) begin
            chk(stall == 1'b1, "R1 stall after load", stall, 1);
            pending_load = 0;
         end
         if (stall) begin
            if (q.size() == 0) begin
               chk(1'b0, "R7/R9 transfer with no accepted word", stall, 0);
            end else if (shift_en) begin
               chk(ser_out == q[0].chunk, "R2/R3/R10 chunk order", ser_out, q[0].chunk);
               if (q[0].last) pending_done = 1;
               void'(q.pop_front());
            end else begin
               chk(ser_out == q[0].chunk, "R4 hold without shift", ser_out, q[0].chunk);
            end
         end else begin
            chk(ser_out == '0, "R11 idle output zero", ser_out, 0);
            if (ld_valid) begin
               push_word(ld_data, lsb_first);  // R8: shift_en ignored here
               pending_load = 1;
            end
         end
      end
   end

   task automatic step(input logic v, input logic [W-1:0] d, input logic lsb, input logic sh);
      ld_valid  = v;
      ld_data   = d;
      lsb_first = lsb;
      shift_en  = sh;
      @(posedge clk);
      #1;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, 1'b0);
   endtask

   task automatic summary;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      chk(1'b0, "watchdog expired", 0, 1);
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(stall == 1'b0, "R11 reset stall", stall, 0);
      chk(done == 1'b0, "R11 reset done", done, 0);
      chk(ser_out == '0, "R11 reset ser_out", ser_out, 0);
      @(posedge clk);
      #1;
      rst_n = 1'b1;
      idle(2);

      // R1 R2: MSB-first, continuous shifting
      step(1'b1, 8'hB4, 1'b0, 1'b0);
      for (int i = 0; i < STEPS; i++) step(1'b0, '0, 1'b0, 1'b1);
      idle(2);

      // R3 R4: LSB-first with gaps in shift_en
      step(1'b1, 8'h6C, 1'b1, 1'b0);
      step(1'b0, '0, 1'b0, 1'b1);
      step(1'b0, '0, 1'b0, 1'b0);
      step(1'b0, '0, 1'b0, 1'b1);
      step(1'b0, '0, 1'b0, 1'b0);
      step(1'b0, '0, 1'b0, 1'b0);
      step(1'b0, '0, 1'b0, 1'b1);
      step(1'b0, '0, 1'b0, 1'b1);
      idle(2);

      // R7 R10: loads offered mid-transfer are ignored, mode changes too
      step(1'b1, 8'h3A, 1'b0, 1'b0);
      step(1'b1, 8'hFF, 1'b0, 1'b1);
      step(1'b1, 8'h00, 1'b1, 1'b0);
      step(1'b1, 8'hC5, 1'b1, 1'b1);
      step(1'b0, '0, 1'b1, 1'b1);
      step(1'b0, '0, 1'b0, 1'b1);
      idle(2);

      // R8: load and shift together while idle
      step(1'b1, 8'h93, 1'b1, 1'b1);
      for (int i = 0; i < STEPS; i++) step(1'b0, '0, 1'b1, 1'b1);
      idle(2);

      // R9: back-to-back, next word held across the final shift
      step(1'b1, 8'hA1, 1'b0, 1'b1);
      for (int i = 0; i < STEPS; i++) step(1'b1, 8'h5E, 1'b1, 1'b1);
      step(1'b1, 8'h5E, 1'b1, 1'b1);
      for (int i = 0; i < STEPS; i++) step(1'b0, '0, 1'b0, 1'b1);
      idle(2);

      // R10: lsb_first toggled between shifts
      step(1'b1, 8'hD2, 1'b1, 1'b0);
      step(1'b0, '0, 1'b0, 1'b1);
      step(1'b0, '0, 1'b1, 1'b0);
      for (int i = 0; i < STEPS - 1; i++) step(1'b0, '0, 1'b0, 1'b1);
      idle(3);

      chk(q.size() == 0, "R5 all chunks delivered", q.size(), 0);
      summary();
      $finish;
   end
endmodule